// File: doc/BRIEF.md
# Guard-Timed Frame Transmit Scheduler

This block decides when an outgoing frame may go on the air and then feeds it, byte by byte, to a serial transmit stage. It keeps a free-running tick count, where one tick stands for 16 carrier periods and advances once per clock. A register holds the earliest tick at which a new transmission is allowed. Two events raise it. The first is a transmission start, which adds a request guard interval. The second is a reply-received pulse, which adds a frame-delay interval less a fixed pipeline compensation. The register never moves backwards.

When a start request arrives, the block takes the later of the earliest allowed tick and the current tick. It clears the three low bits of that value and adds 8, so every launch lands on an 8-tick boundary strictly in the future. It waits for that tick and records it as the start tick. It then sends a run of zero bytes, the frame read from a buffer port at addresses 0 upward, and a short zero trailer. Each byte moves only on a cycle where the transmit stage reports ready.

Top module: `frame_tx_scheduler`

## Requirements
- R1: After reset, `busy` and `tx_strobe` are 0 and `start_tick` is 0. The tick count is 0 on the first rising edge with reset released and advances by one per clock. The earliest allowed tick starts at `RESET_EARLIEST` (default 418).
- R2: A request seen at a rising edge whose pre-edge tick is T sets the launch tick to `(max(earliest, T) & ~7) + 8`. `start_tick` takes that value on the edge where the tick count equals it, and the first byte is offered on the next cycle.
- R3: A launch at tick S raises the earliest allowed tick to at least S + `GUARD_TICKS` (default 426).
- R4: A `reply_done` pulse at pre-edge tick t raises the earliest allowed tick to at least `(t & ~7) + FRAME_DELAY_TICKS - PIPE_COMP_TICKS` (default 168 - 18 = 150).
- R5: The earliest allowed tick is the maximum of all constraints seen since reset. A smaller candidate never lowers it, and when the current tick is already later, the current tick decides the launch.
- R6: Each transmission begins with `PRE_BYTES` (default 6) bytes of value 0x00.
- R7: After the preamble, frame bytes are sent in order, reading `rd_addr` 0 through `frame_len - 1`. `tx_byte` carries `rd_data` for the address shown.
- R8: After the last frame byte, `POST_BYTES` (default 2) bytes of 0x00 follow, and `busy` then falls.
- R9: A byte counts as sent only on a rising edge where `tx_strobe` is 1. `tx_strobe` is 1 only while `tx_rdy` is 1, and low `tx_rdy` stalls the sequence without losing or repeating bytes.
- R10: A `start_req` that arrives while `busy` is 1 is ignored. No extra frame is sent and `start_tick` does not change.
- R11: A `frame_len` of 0 sends only the preamble followed by the trailer.
- R12: `busy` rises on the edge that accepts a request and stays high until the last trailer byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to send the frame in the buffer |
| frame_len | input | LEN_W | Number of frame bytes, sampled with the request |
| rd_addr | output | LEN_W | Frame buffer read address |
| rd_data | input | 8 | Frame buffer read data, same cycle as address |
| reply_done | input | 1 | Pulse: a received frame has completed |
| tx_rdy | input | 1 | Transmit stage can take a byte |
| tx_byte | output | 8 | Byte offered to the transmit stage |
| tx_strobe | output | 1 | Byte on `tx_byte` is taken this cycle |
| busy | output | 1 | A transmission is waiting or in progress |
| start_tick | output | TICK_W | Tick at which the last transmission started |

## Verification
The hardest case to reach from the ports is a launch where the reply-delay constraint wins over both the guard time and the current tick. The reply pulse must come late enough after the previous start that the guard interval has already run out. The next request must then follow within a few ticks, while the reply constraint is still in the future. The stimulus table reaches this state with a long idle gap, then a reply pulse, then a request on the next cycle. Other rows give cases where the guard time decides the launch, where the current tick decides it, and where an irregular ready pattern stalls the byte stream.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_PRE   = 3'd2,
      ST_DATA  = 3'd3,
      ST_TRAIL = 3'd4
   } ftx_state_e;
endpackage

// File: rtl/ftx_tick_counter.sv
module ftx_tick_counter #(
   parameter int TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TICK_W-1:0] tick
);
   if (TICK_W < 12) begin : g_bad_width
      $error("TICK_W too small for the guard intervals");
   end

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + TICK_W'(1);
   end

   assign tick = cnt_q;

   // R1
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tick == $past(tick) + TICK_W'(1));
endmodule

// File: rtl/ftx_guard_tracker.sv
module ftx_guard_tracker #(
   parameter int TICK_W            = 32,
   parameter int ALIGN_LOG2        = 3,
   parameter int GUARD_TICKS       = 426,
   parameter int FRAME_DELAY_TICKS = 168,
   parameter int PIPE_COMP_TICKS   = 18,
   parameter int RESET_EARLIEST    = 418
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic              launch,
   input  logic [TICK_W-1:0] launch_tick,
   input  logic              reply_done,
   output logic [TICK_W-1:0] earliest
);
   localparam int REPLY_ADD = FRAME_DELAY_TICKS - PIPE_COMP_TICKS;
   localparam logic [TICK_W-1:0] LOW_MASK = TICK_W'((1 << ALIGN_LOG2) - 1);

   if (REPLY_ADD < 0) begin : g_bad_comp
      $error("pipeline compensation exceeds frame delay");
   end
   if (GUARD_TICKS < 1) begin : g_bad_guard
      $error("GUARD_TICKS must be positive");
   end

   logic [TICK_W-1:0] earliest_q;
   logic [TICK_W-1:0] cand_launch, cand_reply, step1, step2;

   always_comb begin
      cand_launch = launch_tick + TICK_W'(GUARD_TICKS);
      cand_reply  = (tick & ~LOW_MASK) + TICK_W'(REPLY_ADD);
      step1 = earliest_q;
      if (launch && cand_launch > step1) step1 = cand_launch;
      step2 = step1;
      if (reply_done && cand_reply > step2) step2 = cand_reply;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) earliest_q <= TICK_W'(RESET_EARLIEST);
      else        earliest_q <= step2;
   end

   assign earliest = earliest_q;

   // R5
   earliest_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> earliest >= $past(earliest));
   // R3
   guard_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> earliest >= $past(launch_tick) + TICK_W'(GUARD_TICKS));
   // R4
   reply_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reply_done |=> earliest >= ($past(tick) & ~LOW_MASK) + TICK_W'(REPLY_ADD));
endmodule

// File: rtl/ftx_byte_sequencer.sv
module ftx_byte_sequencer
   import ftx_pkg::*;
#(
   parameter int TICK_W     = 32,
   parameter int LEN_W      = 9,
   parameter int ALIGN_LOG2 = 3,
   parameter int PRE_BYTES  = 6,
   parameter int POST_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] earliest,
   input  logic              start_req,
   input  logic [LEN_W-1:0]  frame_len,
   output logic [LEN_W-1:0]  rd_addr,
   input  logic [7:0]        rd_data,
   input  logic              tx_rdy,
   output logic [7:0]        tx_byte,
   output logic              tx_strobe,
   output logic              busy,
   output logic              launch,
   output logic [TICK_W-1:0] launch_tick,
   output logic [TICK_W-1:0] start_tick
);
   localparam int CNT_MAX = (PRE_BYTES > POST_BYTES) ? PRE_BYTES : POST_BYTES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [TICK_W-1:0] LOW_MASK = TICK_W'((1 << ALIGN_LOG2) - 1);
   localparam logic [TICK_W-1:0] STEP     = TICK_W'(1 << ALIGN_LOG2);

   if (PRE_BYTES < 1 || POST_BYTES < 1) begin : g_bad_pad
      $error("padding counts must be at least one");
   end

   ftx_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  idx_q, len_q;
   logic [TICK_W-1:0] target_q, start_q, base;
   logic              sending;

   always_comb begin
      base = (earliest > tick) ? earliest : tick;
   end

   assign sending     = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_TRAIL);
   assign tx_strobe   = sending && tx_rdy;
   assign tx_byte     = (state_q == ST_DATA) ? rd_data : 8'h00;
   assign rd_addr     = idx_q;
   assign busy        = (state_q != ST_IDLE);
   assign launch      = (state_q == ST_WAIT) && (tick == target_q);
   assign launch_tick = target_q;
   assign start_tick  = start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         len_q    <= '0;
         target_q <= '0;
         start_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_req) begin
                  len_q    <= frame_len;
                  target_q <= (base & ~LOW_MASK) + STEP;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (launch) begin
                  start_q <= target_q;
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  state_q <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (tx_strobe) begin
                  if (cnt_q == CNT_W'(PRE_BYTES - 1)) begin
                     cnt_q   <= '0;
                     state_q <= (len_q == '0) ? ST_TRAIL : ST_DATA;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            ST_DATA: begin
               if (tx_strobe) begin
                  if (idx_q == len_q - LEN_W'(1)) state_q <= ST_TRAIL;
                  else                          idx_q   <= idx_q + LEN_W'(1);
               end
            end
            ST_TRAIL: begin
               if (tx_strobe) begin
                  if (cnt_q == CNT_W'(POST_BYTES - 1)) state_q <= ST_IDLE;
                  else                                 cnt_q   <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (start_tick[ALIGN_LOG2-1:0] == '0) && (start_tick == $past(tick)));
   // R10
   ignore_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_req) |=> $stable(target_q) && $stable(len_q));
   // R8
   trail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(state_q == ST_TRAIL) && $past(tx_rdy));
   // R9
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && !tx_rdy) |=> $stable(state_q) && $stable(cnt_q) && $stable(idx_q));
endmodule

// File: rtl/frame_tx_scheduler.sv
module frame_tx_scheduler #(
   parameter int TICK_W            = 32,
   parameter int LEN_W             = 9,
   parameter int ALIGN_LOG2        = 3,
   parameter int PRE_BYTES         = 6,
   parameter int POST_BYTES        = 2,
   parameter int GUARD_TICKS       = 426,
   parameter int FRAME_DELAY_TICKS = 168,
   parameter int PIPE_COMP_TICKS   = 18,
   parameter int TX_PIPE_TICKS     = 209,
   parameter int RESET_EARLIEST    = 2 * TX_PIPE_TICKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [LEN_W-1:0]  frame_len,
   output logic [LEN_W-1:0]  rd_addr,
   input  logic [7:0]        rd_data,
   input  logic              reply_done,
   input  logic              tx_rdy,
   output logic [7:0]        tx_byte,
   output logic              tx_strobe,
   output logic              busy,
   output logic [TICK_W-1:0] start_tick
);
   logic [TICK_W-1:0] tick, earliest, launch_tick;
   logic              launch;

   ftx_tick_counter #(.TICK_W(TICK_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   ftx_guard_tracker #(
      .TICK_W            (TICK_W),
      .ALIGN_LOG2        (ALIGN_LOG2),
      .GUARD_TICKS       (GUARD_TICKS),
      .FRAME_DELAY_TICKS (FRAME_DELAY_TICKS),
      .PIPE_COMP_TICKS   (PIPE_COMP_TICKS),
      .RESET_EARLIEST    (RESET_EARLIEST)
   ) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .launch      (launch),
      .launch_tick (launch_tick),
      .reply_done  (reply_done),
      .earliest    (earliest)
   );

   ftx_byte_sequencer #(
      .TICK_W     (TICK_W),
      .LEN_W      (LEN_W),
      .ALIGN_LOG2 (ALIGN_LOG2),
      .PRE_BYTES  (PRE_BYTES),
      .POST_BYTES (POST_BYTES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .earliest    (earliest),
      .start_req   (start_req),
      .frame_len   (frame_len),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .tx_rdy      (tx_rdy),
      .tx_byte     (tx_byte),
      .tx_strobe   (tx_strobe),
      .busy        (busy),
      .launch      (launch),
      .launch_tick (launch_tick),
      .start_tick  (start_tick)
   );

   // R2
   launch_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> launch_tick > $past(tick));
endmodule

// File: tb/frame_tx_scheduler_tb.sv
module frame_tx_scheduler_tb;
   localparam int TW = 32;
   localparam int LW = 9;

   typedef struct packed {
      logic [8:0]  len;
      logic [7:0]  rdy_pat;
      logic [15:0] gap;
      logic        reply;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{len: 9'd5,  rdy_pat: 8'hFF, gap: 16'd0,   reply: 1'b0},
      '{len: 9'd12, rdy_pat: 8'hA6, gap: 16'd0,   reply: 1'b0},
      '{len: 9'd3,  rdy_pat: 8'hFF, gap: 16'd900, reply: 1'b0},
      '{len: 9'd4,  rdy_pat: 8'hFF, gap: 16'd700, reply: 1'b1}
   };

   logic clk = 0, rst_n = 0, start_req = 0, reply_done = 0, tx_rdy = 0;
   logic [LW-1:0] frame_len = '0, rd_addr;
   logic [7:0] rd_data, tx_byte;
   logic tx_strobe, busy;
   logic [TW-1:0] start_tick;

   logic [7:0] mem [0:511];
   assign rd_data = mem[rd_addr];

   int checks = 0, errors = 0;
   longint btick = 0;
   longint model_e = 418;
   logic [7:0] rdy_pat = 8'hFF;
   int phase = 0;
   logic [7:0] cap [0:599];
   int cap_n = 0;
   longint first_tick = -1;
   bit done = 0;

   always #5 clk = ~clk;

   frame_tx_scheduler u_dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .frame_len(frame_len),
      .rd_addr(rd_addr), .rd_data(rd_data), .reply_done(reply_done),
      .tx_rdy(tx_rdy), .tx_byte(tx_byte), .tx_strobe(tx_strobe),
      .busy(busy), .start_tick(start_tick)
   );

   always @(posedge clk) begin
      if (!rst_n) btick <= 0;
      else        btick <= btick + 1;
   end

   always begin
      @(negedge clk);
      tx_rdy = rdy_pat[phase % 8];
      phase++;
      #1;
      if (tx_strobe) begin
         if (cap_n < 600) cap[cap_n] = tx_byte;
         cap_n++;
         if (first_tick < 0) first_tick = btick;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint launch_of(input longint e, input longint t);
      longint b = (e > t) ? e : t;
      return (b & ~longint'(7)) + 8;
   endfunction

   task automatic fill(input int len);
      for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + len * 11 + 5) & 255);
   endtask

   task automatic run_frame(input int len, input logic [7:0] pat, input string req,
                            input bit ignore_test, output longint s_exp);
      longint t;
      fill(len);
      rdy_pat = pat; cap_n = 0; first_tick = -1;
      @(negedge clk);
      t = btick;
      start_req = 1; frame_len = LW'(len);
      s_exp = launch_of(model_e, t);
      if (s_exp + 426 > model_e) model_e = s_exp + 426;
      @(negedge clk);
      start_req = 0;
      #2;
      // R12 busy from the accepting edge
      check(busy == 1, "R12", "busy after request", busy, 1);
      while (busy) begin
         if (ignore_test && btick == s_exp + 4) begin
            start_req = 1; frame_len = LW'(len + 7);
         end else begin
            start_req = 0;
         end
         @(negedge clk); #2;
      end
      start_req = 0;
      // R2
      check(start_tick == TW'(s_exp), req, "start tick", start_tick, s_exp);
      // R6 R7 R8 stream length
      check(cap_n == len + 8, req, "byte count", cap_n, len + 8);
      for (int i = 0; i < cap_n && i < 600; i++) begin
         logic [7:0] e;
         e = (i < 6 || i >= 6 + len) ? 8'h00 : mem[i - 6];
         if (cap[i] !== e) begin
            check(0, (i < 6) ? "R6" : (i >= 6 + len) ? "R8" : "R7", "byte value", cap[i], e);
            break;
         end
      end
      checks++;
   endtask

   initial begin
      longint s, t;
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      check(busy == 0, "R1", "busy in reset", busy, 0);
      check(tx_strobe == 0, "R1", "strobe in reset", tx_strobe, 0);
      check(start_tick == 0, "R1", "start_tick in reset", start_tick, 0);
      @(negedge clk); rst_n = 1;

      foreach (VECS[k]) begin
         repeat (VECS[k].gap) @(negedge clk);
         if (VECS[k].reply) begin
            @(negedge clk);
            t = btick;
            reply_done = 1;
            if ((t & ~longint'(7)) + 150 > model_e) model_e = (t & ~longint'(7)) + 150;
            @(negedge clk);
            reply_done = 0;
         end
         run_frame(int'(VECS[k].len), VECS[k].rdy_pat,
                   (k == 0) ? "R1" : (k == 1) ? "R3" : (k == 2) ? "R5" : "R4", 0, s);
         if (VECS[k].rdy_pat == 8'hFF)
            // R2 first byte the cycle after launch
            check(first_tick == s + 1, "R2", "first byte tick", first_tick, s + 1);
         else
            // R9 stalls keep the stream intact (checked above); first byte not before launch
            check(first_tick > s, "R9", "first byte after launch", first_tick, s + 1);
      end

      // R11 zero-length frame
      run_frame(0, 8'hFF, "R11", 0, s);
      // R10 request while busy
      run_frame(6, 8'h5B, "R10", 1, s);
      repeat (40) begin
         @(negedge clk); #2;
         if (busy) break;
      end
      check(busy == 0, "R10", "no extra frame", busy, 0);
      check(start_tick == TW'(s), "R10", "start tick kept", start_tick, s);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule